// File: doc/BRIEF.md
# Clause 22 Management Master with Background PHY Poll

This block drives the two-wire management bus of an Ethernet port: a clock line (MDC) and a bidirectional data line (MDIO, exposed here as an output value, an output enable and an input). Software talks to it through four 32-bit registers selected by a 2-bit offset. These are a fixed revision word, a control word holding the enable and the MDC divider, a 32-bit bitmap of responding PHYs, and a command word that launches one read or write to any PHY address and register.

When enabled, a poll engine keeps the bus busy between software commands. It reads register 1 of PHY addresses 0 to 31 in turn and records in the bitmap whether each address answered. A software command always wins the next free bus slot, so it waits for no more than the one poll frame already on the wire. Every frame is 64 MDC periods long: 32 preamble ones, then start, opcode, addresses, turnaround and 16 data bits.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the offsets read as follows. Offset 1 (control) shows bit 31 = 1 (idle), bit 30 = 0 (disabled) and bits 15:0 = DIV_RST. Offset 2 (bitmap) reads 0 and offset 3 (command) reads 0. Offset 0 reads {16'b0, REV_MAJOR, REV_MINOR}.
- R2: While the bus runs, one MDC period lasts div+1 clock cycles, where div is control bits 15:0. A divider of 0 behaves as 1.
- R3: A frame is sent MSB first as 32 ones, then 01, then the opcode (10 read, 01 write), the 5-bit PHY address and the 5-bit register address. On a write the controller then drives turnaround 10 and the 16 data bits.
- R4: The command word holds GO in bit 31, WRITE in bit 30 (0 = read), ACK in bit 29, the register address in bits 25:21, the PHY address in bits 20:16 and the data in bits 15:0. A write to offset 3 while GO reads 1 changes nothing.
- R5: GO stays 1 until the launched frame ends and then reads 0. After a read, ACK is 1 and bits 15:0 hold the PHY's value when the PHY pulled the second turnaround bit low. Otherwise ACK is 0 and bits 15:0 keep the written value. After a write, ACK reads 0.
- R6: MDIO value and enable change only together with a falling MDC edge. On reads the controller releases MDIO from the first turnaround bit to the end of the frame and samples on rising MDC edges.
- R7: While enabled and with GO at 0, the poll engine reads register 1 of PHY addresses 0,1,...,31 in a loop. It sets bitmap bit n when address n acknowledges and clears it when address n fails to acknowledge.
- R8: With GO pending, enable set and the bus free, the software frame starts at the next clock. The total wait from the command write to GO clearing is at most two frames plus a few MDC periods.
- R9: With control bit 30 at 0, no new frame starts, a pending GO stays pending, MDIO stays released and the bitmap holds its value.
- R10: Control bit 31 reads 0 while a frame is on the bus and 1 when none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register offset: 0 revision, 1 control, 2 bitmap, 3 command |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The main function is exercised with a behavioural PHY set on the bench, in which some addresses answer and some stay silent. The block then sees random reads and writes to random address/register pairs, with directed runs at PHY 0 and 31, register 31, and data of all ones and all zeros. Reads to silent addresses tell a true acknowledge apart from the pulled-up idle line. Write-then-read pairs tell correct bit order and turnaround handling apart from a frame that is merely the right length. A command issued while a poll frame is running separates correct arbitration from starvation. Changing which addresses answer between poll passes shows bits being cleared as well as set.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned PHY_AW   = 5;
  localparam int unsigned PHY_CNT  = 1 << PHY_AW;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned HDR_LEN  = 2 + 2 + 2 * PHY_AW;
  localparam int unsigned TA_POS   = PRE_LEN + HDR_LEN;
  localparam int unsigned DAT_POS  = TA_POS + 2;
  localparam int unsigned FRM_BITS = DAT_POS + DATA_W;
  localparam int unsigned IDX_W    = $clog2(FRM_BITS);

  typedef enum logic [1:0] {
    CSR_REV   = 2'd0,
    CSR_CTRL  = 2'd1,
    CSR_ALIVE = 2'd2,
    CSR_CMD   = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic              wr;
    logic [PHY_AW-1:0] phy;
    logic [PHY_AW-1:0] regad;
    logic [DATA_W-1:0] data;
  } mdm_cmd_t;
endpackage

// File: rtl/mdm_mdc_gen.sv
module mdm_mdc_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] eff, half, cnt_q, cnt_d;
  logic [DIV_W:0]   sum;
  logic             mdc_q, mdc_d;

  always_comb begin
    eff  = (div == '0) ? DIV_W'(1) : div;
    sum  = {1'b0, eff} + 1'b1;
    half = sum[DIV_W:1];
    if (!run)              cnt_d = '0;
    else if (cnt_q >= eff) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
    mdc_d    = run && (cnt_d < half);
    rise_stb = mdc_d & ~mdc_q;
    fall_stb = ~mdc_d & mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdm_frame.sv
module mdm_frame
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdm_cmd_t          cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                busy_q, busy_d, wait_q, wait_d, done_q, done_d;
  logic                wr_q, wr_d, ack_q, ack_d, o_q, o_d, oe_q, oe_d;
  logic [IDX_W-1:0]    idx_q, idx_d, didx;
  logic [FRM_BITS-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]   rx_q, rx_d;

  always_comb begin
    busy_d = busy_q; wait_d = wait_q; idx_d = idx_q; tx_d = tx_q;
    wr_d = wr_q; ack_d = ack_q; rx_d = rx_q; o_d = o_q; oe_d = oe_q;
    done_d = 1'b0;
    didx   = wait_q ? '0 : idx_q + 1'b1;
    if (start && !busy_q && !done_q) begin
      busy_d = 1'b1;
      wait_d = 1'b1;
      idx_d  = '0;
      wr_d   = cmd.wr;
      tx_d   = {{PRE_LEN{1'b1}}, 2'b01, (cmd.wr ? 2'b01 : 2'b10),
                cmd.phy, cmd.regad, 2'b10, cmd.data};
    end else if (busy_q) begin
      if (fall_stb) begin
        wait_d = 1'b0;
        idx_d  = didx;
        o_d    = tx_q[IDX_W'(FRM_BITS - 1) - didx];
        oe_d   = wr_q || (didx < IDX_W'(TA_POS));
      end
      if (rise_stb && !wait_q) begin
        if (idx_q == IDX_W'(TA_POS + 1)) ack_d = ~mdio_i;
        if (idx_q >= IDX_W'(DAT_POS))    rx_d  = {rx_q[DATA_W-2:0], mdio_i};
        if (idx_q == IDX_W'(FRM_BITS - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end else if (fall_stb) begin
      oe_d = 1'b0;
      o_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wait_q <= 1'b0; done_q <= 1'b0; idx_q <= '0;
      tx_q <= '0; wr_q <= 1'b0; ack_q <= 1'b0; rx_q <= '0;
      o_q <= 1'b1; oe_q <= 1'b0;
    end else begin
      busy_q <= busy_d; wait_q <= wait_d; done_q <= done_d; idx_q <= idx_d;
      tx_q <= tx_d; wr_q <= wr_d; ack_q <= ack_d; rx_q <= rx_d;
      o_q <= o_d; oe_q <= oe_d;
    end
  end

  assign busy    = busy_q | done_q;
  assign done    = done_q;
  assign ack     = ack_q;
  assign rdata   = rx_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdm_pkg::*;
#(
  parameter int unsigned       DIV_W     = 16,
  parameter logic [DIV_W-1:0]  DIV_RST   = DIV_W'(63),
  parameter logic [PHY_AW-1:0] POLL_REG  = PHY_AW'(1),
  parameter logic [7:0]        REV_MAJOR = 8'd1,
  parameter logic [7:0]        REV_MINOR = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [1:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]         rst_sync;
  logic               rst_ns;
  logic               en_q, en_d, go_q, go_d, uack_q, uack_d, own_q, own_d;
  logic [DIV_W-1:0]   div_q, div_d;
  mdm_cmd_t           ucmd_q, ucmd_d, fcmd;
  logic [PHY_CNT-1:0] alive_q, alive_d;
  logic [PHY_AW-1:0]  ptr_q, ptr_d;
  logic               launch_user, launch_scan, frm_busy, frm_done, frm_ack;
  logic [DATA_W-1:0]  frm_rdata;
  logic               rise_stb, fall_stb, mdc_run;
  logic               unused_wbits;

  assign unused_wbits = ^csr_wdata[29:26];

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  assign launch_user = en_q && go_q && !frm_busy;
  assign launch_scan = en_q && !go_q && !frm_busy;
  assign mdc_run     = en_q || frm_busy || mdio_oe;

  always_comb begin
    fcmd = launch_user ? ucmd_q
                       : '{wr: 1'b0, phy: ptr_q, regad: POLL_REG, data: '0};
  end

  always_comb begin
    en_d = en_q; div_d = div_q; go_d = go_q; uack_d = uack_q;
    ucmd_d = ucmd_q; alive_d = alive_q; ptr_d = ptr_q; own_d = own_q;
    if (launch_user)      own_d = 1'b1;
    else if (launch_scan) own_d = 1'b0;
    if (csr_we && (csr_sel_e'(csr_addr) == CSR_CTRL)) begin
      en_d  = csr_wdata[30];
      div_d = csr_wdata[DIV_W-1:0];
    end
    if (csr_we && (csr_sel_e'(csr_addr) == CSR_CMD) && !go_q) begin
      go_d   = csr_wdata[31];
      uack_d = 1'b0;
      ucmd_d = '{wr: csr_wdata[30], regad: csr_wdata[25:21],
                 phy: csr_wdata[20:16], data: csr_wdata[15:0]};
    end
    if (frm_done) begin
      if (own_q) begin
        go_d   = 1'b0;
        uack_d = !ucmd_q.wr && frm_ack;
        if (!ucmd_q.wr && frm_ack) ucmd_d.data = frm_rdata;
      end else begin
        alive_d[ptr_q] = frm_ack;
        ptr_d          = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q <= 1'b0; div_q <= DIV_RST; go_q <= 1'b0; uack_q <= 1'b0;
      ucmd_q <= '0; alive_q <= '0; ptr_q <= '0; own_q <= 1'b0;
    end else begin
      en_q <= en_d; div_q <= div_d; go_q <= go_d; uack_q <= uack_d;
      ucmd_q <= ucmd_d; alive_q <= alive_d; ptr_q <= ptr_d; own_q <= own_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel_e'(csr_addr))
      CSR_REV:   csr_rdata[15:0] = {REV_MAJOR, REV_MINOR};
      CSR_CTRL: begin
        csr_rdata[31]        = ~frm_busy;
        csr_rdata[30]        = en_q;
        csr_rdata[DIV_W-1:0] = div_q;
      end
      CSR_ALIVE: csr_rdata = 32'(alive_q);
      CSR_CMD:   csr_rdata = {go_q, ucmd_q.wr, uack_q, 3'b000, ucmd_q.regad,
                              ucmd_q.phy, ucmd_q.data};
      default:   csr_rdata = '0;
    endcase
  end

  mdm_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_ns), .run(mdc_run), .div(div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdm_frame u_frm (
    .clk(clk), .rst_n(rst_ns), .start(launch_user || launch_scan), .cmd(fcmd),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(frm_busy), .done(frm_done), .ack(frm_ack), .rdata(frm_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdm_ctrl_chk.sv
module mdm_ctrl_chk
  import mdm_pkg::*;
(
  input logic               clk,
  input logic               rst_ns,
  input logic               en_q,
  input logic               go_q,
  input logic               own_q,
  input logic               frm_busy,
  input logic               frm_done,
  input logic [PHY_CNT-1:0] alive_q,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe
);
  AST_USER_FIRST: assert property (@(posedge clk) disable iff (!rst_ns)
    en_q && go_q && !frm_busy |=> frm_busy && own_q); // R8

  AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    go_q && !(frm_done && own_q) |=> go_q); // R5

  AST_PINS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_ns)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc)); // R6

  AST_ALIVE_BY_SCAN: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(alive_q) |-> $past(frm_done && !own_q)); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    !en_q && !frm_busy |=> !frm_busy); // R9
endmodule

bind mdio_mgmt_ctrl mdm_ctrl_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .en_q(en_q), .go_q(go_q), .own_q(own_q),
  .frm_busy(frm_busy), .frm_done(frm_done), .alive_q(alive_q),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_addr = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en = 1'b0, phy_bit = 1'b1;

  always #5 clk = ~clk;
  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_bad = 0;
  int contention = 0, fmt_err = 0, ta_err = 0, oe_seen = 0;
  logic [31:0] present = 32'hC3A5_0F81;
  logic [15:0] phy_mem [0:1023];
  logic [15:0] exp_mem [0:1023];

  function automatic logic [15:0] init_val(int p, int r);
    return 16'(p * 1031 + r * 97) ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mdio_oe && phy_en) contention++;
    if (mdio_oe) oe_seen++;
  end

  // behavioural PHY set: decodes frames on rising MDC
  initial begin
    int st = 0, ones = 0, cnt = 0, p = 0, r = 0;
    logic [11:0] hdr = '0;
    logic [17:0] wd = '0;
    for (int i = 0; i < 1024; i++) begin
      phy_mem[i] = init_val(i / 32, i % 32);
      exp_mem[i] = init_val(i / 32, i % 32);
    end
    forever begin
      @(posedge mdc);
      case (st)
        0: if (mdio_i) ones++;
           else if (ones >= 32) begin st = 1; ones = 0; end
           else ones = 0;
        1: if (mdio_i) begin st = 2; cnt = 0; hdr = '0; end
           else begin st = 0; ones = 0; end
        2: begin
          hdr = {hdr[10:0], mdio_i};
          cnt++;
          if (cnt == 12) begin
            p = int'(hdr[9:5]); r = int'(hdr[4:0]); cnt = 0;
            if (hdr[11:10] == 2'b10) st = present[p] ? 3 : 5;
            else if (hdr[11:10] == 2'b01) st = 4;
            else begin fmt_err++; st = 5; end
          end
        end
        3: begin
          if (cnt == 0) begin
            if (mdio_oe) ta_err++;
            phy_en = 1'b1; phy_bit = 1'b0;
          end else if (cnt <= 16) phy_bit = phy_mem[p*32+r][16-cnt];
          else begin phy_en = 1'b0; st = 0; ones = 0; end
          cnt++;
        end
        4: begin
          wd = {wd[16:0], mdio_i};
          if (cnt == 0 && !mdio_i) fmt_err++;
          if (cnt == 1 && mdio_i) fmt_err++;
          if (cnt == 17) begin
            if (present[p]) phy_mem[p*32+r] = wd[15:0];
            st = 0; ones = 0;
          end
          cnt++;
        end
        default: begin
          if (cnt == 17) begin st = 0; ones = 0; end
          cnt++;
        end
      endcase
    end
  end

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); csr_addr = a; #1 d = csr_rdata;
  endtask

  task automatic user_go(input bit wr, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d);
    csr_wr(2'd3, {1'b1, wr, 1'b0, 3'b000, r, p, d});
  endtask

  task automatic user_wait(output logic [31:0] v, output int cyc);
    cyc = 0;
    do begin csr_rd(2'd3, v); cyc++; end while (v[31] && cyc < 4000);
  endtask

  task automatic access(input bit wr, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d);
    logic [31:0] v;
    int cyc, ix;
    bit pr;
    ix = int'(p) * 32 + int'(r);
    pr = present[p];
    user_go(wr, p, r, d);
    csr_rd(2'd1, v);
    check(v[31] == 1'b0, "R10 busy flag", {31'b0, v[31]}, 32'd0);
    user_wait(v, cyc);
    check(v[31] == 1'b0, "R5 GO clears", v, {1'b0, v[30:0]});
    check(cyc <= 2 * 66 * 4 + 16, "R8 latency", 32'(cyc), 32'(2 * 66 * 4 + 16));
    check(v[30] == wr && v[25:21] == r && v[20:16] == p, "R4 fields",
          v, {1'b0, wr, 4'b0, r, p, 16'b0});
    if (wr) begin
      if (pr) exp_mem[ix] = d;
      check(v[29] == 1'b0 && v[15:0] == d, "R5 write ack/data",
            v, {16'b0, d});
      check(phy_mem[ix] == exp_mem[ix], "R3 write reaches PHY",
            32'(phy_mem[ix]), 32'(exp_mem[ix]));
    end else begin
      check(v[29] == pr && v[15:0] == (pr ? exp_mem[ix] : d), "R5 read ack/data",
            {v[29], v[15:0]}, {pr, (pr ? exp_mem[ix] : d)});
    end
  endtask

  task automatic period(output int n);
    logic pm;
    n = 0;
    @(posedge mdc); #1;
    do begin
      pm = mdc; @(posedge clk); #1; n++;
    end while (!(mdc && !pm) && n < 100000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, a1;
    int n, cyc, o1;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    csr_rd(2'd1, v); check(v == 32'h8000_003F, "R1 control", v, 32'h8000_003F);
    csr_rd(2'd2, v); check(v == 32'h0, "R1 bitmap", v, 32'h0);
    csr_rd(2'd3, v); check(v == 32'h0, "R1 command", v, 32'h0);
    csr_rd(2'd0, v); check(v == 32'h0000_0104, "R1 revision", v, 32'h0000_0104);

    csr_wr(2'd1, 32'h4000_0003);
    period(n); period(n); check(n == 4, "R2 div3", 32'(n), 32'd4);
    csr_wr(2'd1, 32'h4000_0006);
    period(n); period(n); check(n == 7, "R2 div6", 32'(n), 32'd7);
    csr_wr(2'd1, 32'h4000_0000);
    period(n); period(n); check(n == 2, "R2 div0", 32'(n), 32'd2);
    csr_wr(2'd1, 32'h4000_0003);
    repeat (600) @(negedge clk);

    // directed corners
    access(1'b0, 5'd0, 5'd0, 16'h0000);
    access(1'b0, 5'd31, 5'd31, 16'h1111);
    access(1'b1, 5'd31, 5'd31, 16'hFFFF);
    access(1'b0, 5'd31, 5'd31, 16'h2222);
    access(1'b1, 5'd0, 5'd5, 16'h0000);
    access(1'b0, 5'd0, 5'd5, 16'hFFFF);
    access(1'b0, 5'd1, 5'd3, 16'hCAFE);
    access(1'b1, 5'd1, 5'd3, 16'h7777);
    for (int k = 0; k < 24; k++)
      access(1'(($urandom() >> 3) & 1), 5'($urandom()), 5'($urandom()),
             16'($urandom()));

    // R4: second command while GO is set is ignored
    user_go(1'b0, 5'd7, 5'd2, 16'h1234);
    csr_wr(2'd3, {1'b1, 1'b1, 1'b0, 3'b000, 5'd9, 5'd0, 16'hBEEF});
    user_wait(v, cyc);
    check(v[30] == 1'b0 && v[25:21] == 5'd2 && v[20:16] == 5'd7,
          "R4 ignore while busy", v, {2'b00, 9'b0, 5'd2, 5'd7, 16'b0});
    check(v[15:0] == exp_mem[7*32+2], "R4 first command data",
          32'(v[15:0]), 32'(exp_mem[7*32+2]));
    check(phy_mem[9] == exp_mem[9], "R4 no write issued",
          32'(phy_mem[9]), 32'(exp_mem[9]));

    // R7: poll passes set and clear bitmap bits
    repeat (17500) @(negedge clk);
    csr_rd(2'd2, v); check(v == present, "R7 bitmap pass 1", v, present);
    present = present ^ 32'h0F0F_0011;
    repeat (17500) @(negedge clk);
    csr_rd(2'd2, v); check(v == present, "R7 bitmap after change", v, present);

    // R9: disabled controller stays quiet
    csr_wr(2'd1, 32'h0000_0003);
    repeat (400) @(negedge clk);
    csr_rd(2'd2, a1);
    o1 = oe_seen;
    present = ~present;
    user_go(1'b0, 5'd7, 5'd4, 16'h4321);
    repeat (2000) @(negedge clk);
    csr_rd(2'd3, v); check(v[31] == 1'b1, "R9 GO pending", v, {1'b1, v[30:0]});
    csr_rd(2'd2, v); check(v == a1, "R9 bitmap holds", v, a1);
    check(oe_seen == o1, "R9 MDIO released", 32'(oe_seen), 32'(o1));
    csr_rd(2'd1, v); check(v[31] == 1'b1, "R10 idle when stopped", v, {1'b1, v[30:0]});
    csr_wr(2'd1, 32'h4000_0003);
    user_wait(v, cyc);
    check(v[31] == 1'b0 && v[29] == present[7], "R9 resumes on enable",
          {v[31], v[29]}, {1'b0, present[7]});

    check(fmt_err == 0, "R3 frame format", 32'(fmt_err), 32'd0);
    check(ta_err == 0, "R6 read turnaround released", 32'(ta_err), 32'd0);
    check(contention == 0, "R6 no bus contention", 32'(contention), 32'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule